// File: doc/BRIEF.md
# Sign-Driven Weight Tuning Sequencer

This block sequences one on-chip learning iteration for a crossbar that stores every weight as a positive and a negative conductance cell. On `start_i` it latches the sign and activity of every input row. It then raises a forward request to the array and holds it until the array answers with `fwd_done_i`. On that answer it latches each output column's error sign and checks the error magnitude against a programmable threshold. Only the threshold result is kept; no magnitude arithmetic is carried forward.

The block then walks the rows twice, first in a SET phase and then in a RESET phase. It spends exactly one cycle per row and drives the pulse enables for every column of that row in that same cycle. The tuning is open loop: there is no read-back and no wait between rows. The direction for a weight is the product of the row's input sign and the column's error sign. Only one cell of a pair is pulsed in any cycle. A one-cycle `done_o` ends the iteration. The analog array, the converters and the pulse shaping sit outside this block.

Top module: `sign_tune_ctrl`

## Requirements
- R1: After reset the block is idle: `fwd_req_o`, `done_o`, `set_en_o` and `reset_en_o` are all 0 and `row_o` is 0.
- R2: A `start_i` sampled while idle raises `fwd_req_o` in the next cycle. `fwd_req_o` stays high until `fwd_done_i` is sampled. The SET phase then covers rows 0 to N_ROWS-1, followed by the RESET phase over the same rows. After that, `done_o` is high for exactly one cycle and the block returns to idle.
- R3: `start_i` has no effect unless the block is idle. `fwd_done_i` has no effect unless the forward request is pending.
- R4: In each tuning phase `row_o` starts at 0 and advances by one every cycle, with no stall and no read-back.
- R5: Column c drives cell bit 2c (positive cell) and bit 2c+1 (negative cell). The direction is negative when the row's `in_neg_i` bit differs from the column's `err_neg_i` bit. In the SET phase a positive direction sets bit 2c and a negative direction sets bit 2c+1.
- R6: In the RESET phase a positive direction resets bit 2c+1 and a negative direction resets bit 2c.
- R7: Column c is pulsed only if its unsigned magnitude `err_mag_i[c*MAG_W +: MAG_W]` is greater than or equal to `thr_i`, as sampled with `fwd_done_i`. A magnitude equal to the threshold pulses; a magnitude one below does not.
- R8: A row whose `in_act_i` bit is 0 gets no pulse in either phase.
- R9: The input signs are captured only at the accepted start. The error signs, magnitudes and threshold are captured only at the accepted `fwd_done_i`. Later changes on these inputs do not alter the pulses of the running iteration.
- R10: In no cycle are both cells of a pair enabled. In no cycle are SET and RESET enables active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an iteration (accepted when idle) |
| in_act_i | input | N_ROWS | Row input active (nonzero sign) |
| in_neg_i | input | N_ROWS | Row input sign, 1 = negative |
| fwd_req_o | output | 1 | Forward multiply requested from the array |
| fwd_done_i | input | 1 | Array finished the forward pass |
| err_neg_i | input | N_COLS | Column error sign, 1 = negative |
| err_mag_i | input | N_COLS*MAG_W | Column error magnitudes, column c at c*MAG_W |
| thr_i | input | MAG_W | Update threshold on error magnitude |
| row_o | output | ROW_W | Row being tuned |
| set_en_o | output | 2*N_COLS | SET pulse enables, bit 2c positive, 2c+1 negative cell |
| reset_en_o | output | 2*N_COLS | RESET pulse enables, same cell layout |
| done_o | output | 1 | One-cycle end of iteration |

## Verification
The pulse map is checked row by row against a model of the sign rule under several input patterns:
- Fully active random signs with a zero threshold: every column must pulse, which separates the four sign combinations in both phases.
- Magnitudes at, one below and one above the threshold: this isolates the greater-or-equal comparison.
- Half the rows inactive: this separates row skipping from column gating.
- Inputs scrambled after each capture point, with stray start and forward-done pulses during tuning: this distinguishes correct capture timing and ignored controls from live pass-through.

// File: rtl/sign_tune_pkg.sv
package sign_tune_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FWD,
    PH_SET,
    PH_RST,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/sign_tune_seq.sv
module sign_tune_seq
  import sign_tune_pkg::*;
#(
  parameter int N_ROWS = 100,
  localparam int ROW_W = $clog2(N_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fwd_done_i,
  output phase_e           phase_o,
  output logic [ROW_W-1:0] row_o,
  output logic             cap_in_o,
  output logic             cap_err_o
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(N_ROWS - 1);

  phase_e           phase_q, phase_d;
  logic [ROW_W-1:0] row_q, row_d;

  assign cap_in_o  = (phase_q == PH_IDLE) && start_i;
  assign cap_err_o = (phase_q == PH_FWD) && fwd_done_i;

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_FWD;
      PH_FWD: if (fwd_done_i) begin
        phase_d = PH_SET;
        row_d   = '0;
      end
      PH_SET, PH_RST: begin
        if (row_q == LAST) begin
          row_d   = '0;
          phase_d = (phase_q == PH_SET) ? PH_RST : PH_DONE;
        end else begin
          row_d = row_q + 1'b1;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
    end
  end

  assign phase_o = phase_q;
  assign row_o   = row_q;

  // R4
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_SET || phase_q == PH_RST) && row_q != LAST)
      |=> (row_q == $past(row_q) + 1'b1));
  // R2
  set_to_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SET && row_q == LAST) |=> (phase_q == PH_RST && row_q == '0));
  // R2
  fwd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FWD && !fwd_done_i) |=> (phase_q == PH_FWD));
  // R3
  start_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SET && row_q != LAST) |=> (phase_q == PH_SET));
endmodule

// File: rtl/sign_tune_pulse.sv
module sign_tune_pulse
  import sign_tune_pkg::*;
#(
  parameter int N_COLS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  phase_e              phase_i,
  input  logic                row_act_i,
  input  logic                row_neg_i,
  input  logic [N_COLS-1:0]   err_neg_i,
  input  logic [N_COLS-1:0]   col_en_i,
  output logic [2*N_COLS-1:0] set_en_o,
  output logic [2*N_COLS-1:0] reset_en_o
);
  logic set_ph, rst_ph;
  assign set_ph = (phase_i == PH_SET);
  assign rst_ph = (phase_i == PH_RST);

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic dir_neg, on;
    assign dir_neg = row_neg_i ^ err_neg_i[c];
    assign on      = row_act_i & col_en_i[c];
    // SET grows the cell on the direction's side; RESET shrinks the other
    assign set_en_o[2*c]     = on & set_ph & ~dir_neg;
    assign set_en_o[2*c+1]   = on & set_ph & dir_neg;
    assign reset_en_o[2*c]   = on & rst_ph & dir_neg;
    assign reset_en_o[2*c+1] = on & rst_ph & ~dir_neg;

    // R10
    pair_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((set_en_o[2*c] | reset_en_o[2*c]) && (set_en_o[2*c+1] | reset_en_o[2*c+1])));
  end

  // R10
  set_rst_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|set_en_o) && (|reset_en_o)));
endmodule

// File: rtl/sign_tune_ctrl.sv
module sign_tune_ctrl
  import sign_tune_pkg::*;
#(
  parameter int N_ROWS = 100,
  parameter int N_COLS = 10,
  parameter int MAG_W  = 8,
  localparam int ROW_W = $clog2(N_ROWS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_ROWS-1:0]       in_act_i,
  input  logic [N_ROWS-1:0]       in_neg_i,
  output logic                    fwd_req_o,
  input  logic                    fwd_done_i,
  input  logic [N_COLS-1:0]       err_neg_i,
  input  logic [N_COLS*MAG_W-1:0] err_mag_i,
  input  logic [MAG_W-1:0]        thr_i,
  output logic [ROW_W-1:0]        row_o,
  output logic [2*N_COLS-1:0]     set_en_o,
  output logic [2*N_COLS-1:0]     reset_en_o,
  output logic                    done_o
);
  phase_e              phase;
  logic [ROW_W-1:0]    row;
  logic                cap_in, cap_err;
  logic [N_ROWS-1:0]   act_q, neg_q;
  logic [N_COLS-1:0]   eneg_q, colen_q, colen_d;

  sign_tune_seq #(.N_ROWS(N_ROWS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .fwd_done_i(fwd_done_i),
    .phase_o   (phase),
    .row_o     (row),
    .cap_in_o  (cap_in),
    .cap_err_o (cap_err)
  );

  for (genvar c = 0; c < N_COLS; c++) begin : g_thr
    assign colen_d[c] = err_mag_i[c*MAG_W +: MAG_W] >= thr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '0;
      neg_q   <= '0;
      eneg_q  <= '0;
      colen_q <= '0;
    end else begin
      if (cap_in) begin
        act_q <= in_act_i;
        neg_q <= in_neg_i;
      end
      if (cap_err) begin
        eneg_q  <= err_neg_i;
        colen_q <= colen_d;
      end
    end
  end

  sign_tune_pulse #(.N_COLS(N_COLS)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .row_act_i (act_q[row]),
    .row_neg_i (neg_q[row]),
    .err_neg_i (eneg_q),
    .col_en_i  (colen_q),
    .set_en_o  (set_en_o),
    .reset_en_o(reset_en_o)
  );

  assign fwd_req_o = (phase == PH_FWD);
  assign done_o    = (phase == PH_DONE);
  assign row_o     = row;

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !fwd_req_o);
  // R1
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_req_o || done_o) |-> (set_en_o == '0 && reset_en_o == '0));
  // R8
  skip_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q[row] |-> (set_en_o == '0 && reset_en_o == '0));
endmodule

// File: tb/sign_tune_ctrl_test.sv
`timescale 1ns/1ps
module sign_tune_ctrl_test;
  localparam int N_ROWS = 100;
  localparam int N_COLS = 10;
  localparam int MAG_W  = 8;
  localparam int ROW_W  = $clog2(N_ROWS);
  localparam int NC2    = 2 * N_COLS;

  typedef struct packed {
    logic             ph;
    logic [ROW_W-1:0] row;
    logic [NC2-1:0]   set;
    logic [NC2-1:0]   rst;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, fwd_done = 1'b0;
  logic [N_ROWS-1:0] in_act = '0, in_neg = '0;
  logic [N_COLS-1:0] err_neg = '0;
  logic [N_COLS*MAG_W-1:0] err_mag = '0;
  logic [MAG_W-1:0] thr = '0;
  logic fwd_req, done;
  logic [ROW_W-1:0] row;
  logic [NC2-1:0] set_en, reset_en;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_tag = "";
  exp_t q[$];

  always #4 clk = ~clk;

  sign_tune_ctrl #(.N_ROWS(N_ROWS), .N_COLS(N_COLS), .MAG_W(MAG_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_act_i(in_act),
    .in_neg_i(in_neg), .fwd_req_o(fwd_req), .fwd_done_i(fwd_done),
    .err_neg_i(err_neg), .err_mag_i(err_mag), .thr_i(thr), .row_o(row),
    .set_en_o(set_en), .reset_en_o(reset_en), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s (%s): actual=%h expected=%h", tag, what, cur_tag, act, exp);
    end
  endtask

  function automatic logic [N_ROWS-1:0] rnd_rows();
    logic [N_ROWS-1:0] v;
    for (int i = 0; i < N_ROWS; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  // monitor: pops one expected row per tuning cycle
  initial forever begin
    @(negedge clk);
    if (q.size() > 0 && !fwd_req) begin
      exp_t it;
      it = q.pop_front();
      chk(row == it.row, "R4", "row index", 64'(row), 64'(it.row));
      chk(set_en == it.set && reset_en == it.rst, it.ph ? "R6" : "R5",
          "pulse enables", {set_en, reset_en}, {it.set, it.rst});
      begin
        bit clash;
        clash = (set_en != '0) && (reset_en != '0);
        for (int c = 0; c < N_COLS; c++)
          if ((set_en[2*c] | reset_en[2*c]) && (set_en[2*c+1] | reset_en[2*c+1])) clash = 1;
        chk(!clash, "R10", "pair exclusivity", {set_en, reset_en}, 64'd0);
      end
    end
  end

  task automatic run_iter(input string tag, input logic [N_ROWS-1:0] act,
                          input logic [N_ROWS-1:0] neg, input logic [N_COLS-1:0] eneg,
                          input logic [N_COLS*MAG_W-1:0] mag, input logic [MAG_W-1:0] th,
                          input bit poke);
    cur_tag = tag;
    in_act = act; in_neg = neg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fwd_req == 1'b1, "R2", "forward request raised", 64'(fwd_req), 64'd1);
    // R9: scramble row inputs after capture
    in_act = rnd_rows(); in_neg = rnd_rows();
    repeat (2) begin
      @(negedge clk);
      chk(fwd_req == 1'b1 && set_en == '0, "R2", "forward request held", 64'(fwd_req), 64'd1);
    end
    for (int ph = 0; ph < 2; ph++)
      for (int r = 0; r < N_ROWS; r++) begin
        exp_t it;
        it.ph = 1'(ph); it.row = ROW_W'(r); it.set = '0; it.rst = '0;
        for (int c = 0; c < N_COLS; c++) begin
          bit on, dn;
          on = act[r] && (mag[c*MAG_W +: MAG_W] >= th);
          dn = neg[r] ^ eneg[c];
          if (on) begin
            if (ph == 0) begin it.set[2*c] = !dn; it.set[2*c+1] = dn; end
            else begin it.rst[2*c] = dn; it.rst[2*c+1] = !dn; end
          end
        end
        q.push_back(it);
      end
    err_neg = eneg; err_mag = mag; thr = th;
    fwd_done = 1'b1;
    @(negedge clk);
    fwd_done = 1'b0;
    // R9: scramble error inputs after capture
    err_neg = ~eneg; err_mag = ~mag; thr = ~th;
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1; fwd_done = 1'b1;   // R3: both must be ignored
      @(negedge clk);
      start = 1'b0; fwd_done = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
    chk(done == 1'b1, "R2", "done pulse", 64'(done), 64'd1);
    @(negedge clk);
    chk(done == 1'b0 && fwd_req == 1'b0, "R2", "done one cycle, idle",
        {done, fwd_req}, 64'd0);
  endtask

  initial begin
    logic [N_COLS*MAG_W-1:0] m;
    repeat (3) @(negedge clk);
    cur_tag = "reset";
    chk(fwd_req == 0 && done == 0 && set_en == '0 && reset_en == '0 && row == '0,
        "R1", "reset state", {fwd_req, done, set_en, reset_en, row}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: forward-done while idle is ignored
    cur_tag = "idle fwd_done";
    fwd_done = 1'b1;
    @(negedge clk);
    fwd_done = 1'b0;
    @(negedge clk);
    chk(fwd_req == 0 && set_en == '0 && reset_en == '0 && done == 0, "R3",
        "idle ignores fwd_done", {fwd_req, done, set_en, reset_en}, 64'd0);

    // all active, zero threshold: every column pulses
    m = '0;
    for (int c = 0; c < N_COLS; c++) m[c*MAG_W +: MAG_W] = MAG_W'($urandom);
    run_iter("all-active R5", '1, rnd_rows(), N_COLS'($urandom), m, '0, 0);

    // threshold boundary R7
    for (int c = 0; c < N_COLS; c++)
      m[c*MAG_W +: MAG_W] = (c % 3 == 0) ? 8'd50 : (c % 3 == 1) ? 8'd49 : 8'd51;
    run_iter("threshold R7", '1, rnd_rows(), N_COLS'($urandom), m, 8'd50, 0);

    // inactive rows R8
    for (int c = 0; c < N_COLS; c++) m[c*MAG_W +: MAG_W] = 8'd200;
    run_iter("inactive rows R8", rnd_rows(), rnd_rows(), N_COLS'($urandom), m, 8'd10, 0);

    // stray controls during tuning R3 / R9
    for (int c = 0; c < N_COLS; c++) m[c*MAG_W +: MAG_W] = MAG_W'($urandom);
    run_iter("stray controls R3 R9", rnd_rows(), rnd_rows(), N_COLS'($urandom), m, 8'd100, 1);

    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < N_COLS; c++) m[c*MAG_W +: MAG_W] = MAG_W'($urandom);
      run_iter("random R10", rnd_rows(), rnd_rows(), N_COLS'($urandom), m,
               MAG_W'($urandom), 1'(k));
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule